// File: doc/BRIEF.md
# Iterative AND-Rotate-XOR Feistel Round Engine

This block is the encryption datapath of a lightweight Feistel block cipher. The block is 2n bits wide and is held as two n-bit words, an upper one and a lower one. One round completes per clock cycle. Each round mixes two left rotations of the upper word through a bitwise AND, XORs in a third rotation, the lower word and a round key, and then moves the words along. The same pair of state registers is overwritten every round, so storage does not grow with the round count.

A start strobe loads the plaintext and a round count. The engine then fetches one key word per round from an external key schedule. It raises a request together with a round index and consumes the returned word in the same cycle. When the last round has been written, a one-cycle done pulse marks the ciphertext as valid. The ciphertext stays on the output until the next accepted start. Common settings run 32 rounds for a 16-bit word and up to 72 rounds for a 64-bit word. The count is an input, so any configuration can be driven. No key whitening is applied before or after the rounds.

Top module: `feistel_round_engine`

## Requirements
- R1: While reset is held and after its release, `ct_o` is zero, and `done_o`, `busy_o` and `key_req_o` are low.
- R2: An accepted start loads plaintext bits [2n-1:n] into the upper word and bits [n-1:0] into the lower word. `ct_o` is {upper, lower}, so it equals the plaintext in the cycle after the start.
- R3: Each round computes new_upper = (ROL1(u) & ROL8(u)) ^ ROL2(u) ^ l ^ k. Here u is the upper word, l is the lower word, k is `key_i` in that cycle, and ROLs means rotate left by s bits.
- R4: In each round the old upper word becomes the new lower word.
- R5: In every round cycle `key_req_o` is high and `key_idx_o` holds the round number. It is 0 in the first round and rises by one per round. `key_req_o` is low in all other cycles.
- R6: With a round count R ≥ 1 sampled at the start edge, exactly R rounds run. `done_o` is high in the cycle that follows the R-th round edge, which is R+1 cycles after the start edge.
- R7: `done_o` is high for one cycle per operation. `ct_o` does not change while the engine is idle and no start is given.
- R8: A start given while rounds are in progress has no effect on the state, the round count or the result.
- R9: A round count of zero loads the plaintext, asserts `done_o` in the next cycle with `ct_o` equal to the plaintext, and makes no key request.
- R10: No whitening is applied. An all-zero plaintext with all-zero round keys gives an all-zero ciphertext.
- R11: A start given in the cycle in which `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| pt_i | input | 2*WORD_W | Plaintext, upper word in the high half |
| rounds_i | input | RND_W | Number of rounds for this operation |
| key_i | input | WORD_W | Round key for the index being requested |
| key_req_o | output | 1 | A round is executed this cycle and consumes key_i |
| key_idx_o | output | RND_W | Index of the round key needed this cycle |
| ct_o | output | 2*WORD_W | Current state; ciphertext once done has pulsed |
| busy_o | output | 1 | Rounds are in progress |
| done_o | output | 1 | One-cycle pulse: ciphertext valid |

## Verification
After a start edge, `ct_o` shows the loaded plaintext one cycle later. Each round is then visible one cycle after its edge. `done_o` follows R+1 cycles after the start edge, or 1 cycle after it for a zero count. The bench drives inputs on falling edges, and its model advances on the rising edge. The bench compares the state, the key request, the index and the done flag on every falling edge, which is half a cycle after the register that drives them has updated. Each operation also counts falling edges from start to done and compares the total with R+1. It compares the final ciphertext with a separate loop that computes the whole encryption at once.

// File: rtl/feistel_pkg.sv
package feistel_pkg;

  localparam int unsigned MAX_W = 128;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} ctrl_state_t;

  function automatic logic [MAX_W-1:0] width_mask(input int unsigned w);
    if (w >= MAX_W) return '1;
    return (MAX_W'(1) << w) - MAX_W'(1);
  endfunction

  // left rotation of the low w bits of x by s (s < w)
  function automatic logic [MAX_W-1:0] rotl_w(input logic [MAX_W-1:0] x,
                                              input int unsigned s,
                                              input int unsigned w);
    logic [MAX_W-1:0] xm;
    xm = x & width_mask(w);
    return ((xm << s) | (xm >> (w - s))) & width_mask(w);
  endfunction

  // nonlinear mixing of one round: new upper word
  function automatic logic [MAX_W-1:0] round_mix(input logic [MAX_W-1:0] up,
                                                 input logic [MAX_W-1:0] lo,
                                                 input logic [MAX_W-1:0] rk,
                                                 input int unsigned w);
    logic [MAX_W-1:0] t;
    t = (rotl_w(up, 1, w) & rotl_w(up, 8, w)) ^ rotl_w(up, 2, w);
    return (t ^ lo ^ rk) & width_mask(w);
  endfunction

endpackage

// File: rtl/feistel_round.sv
module feistel_round #(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] up_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] rk_i,
  output logic [WORD_W-1:0] nxt_o
);
  import feistel_pkg::*;

  logic [MAX_W-1:0] up_ext, lo_ext, rk_ext, mix;

  assign up_ext = MAX_W'(up_i);
  assign lo_ext = MAX_W'(lo_i);
  assign rk_ext = MAX_W'(rk_i);
  assign mix    = round_mix(up_ext, lo_ext, rk_ext, WORD_W);
  assign nxt_o  = mix[WORD_W-1:0];

endmodule

// File: rtl/feistel_ctrl.sv
module feistel_ctrl #(
  parameter int unsigned RND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [RND_W-1:0] rounds_i,
  output logic             load_o,
  output logic             round_o,
  output logic             last_o,
  output logic [RND_W-1:0] idx_o,
  output logic             done_o
);
  import feistel_pkg::*;

  ctrl_state_t      st_q;
  logic [RND_W-1:0] idx_q;
  logic [RND_W-1:0] lim_q;
  logic             done_q;

  assign load_o  = (st_q == ST_IDLE) && start_i;
  assign round_o = (st_q == ST_RUN);
  assign last_o  = round_o && (idx_q == lim_q - RND_W'(1));
  assign idx_o   = round_o ? idx_q : '0;
  assign done_o  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      lim_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            idx_q <= '0;
            lim_q <= rounds_i;
            if (rounds_i == '0) done_q <= 1'b1;
            else                st_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (last_o) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + RND_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/feistel_state.sv
module feistel_state #(
  parameter int unsigned WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                round_i,
  input  logic [2*WORD_W-1:0] pt_i,
  input  logic [WORD_W-1:0]   rk_i,
  output logic [2*WORD_W-1:0] st_o
);
  logic [WORD_W-1:0] up_q, lo_q, up_nxt;

  feistel_round #(.WORD_W(WORD_W)) u_round (
    .up_i (up_q),
    .lo_i (lo_q),
    .rk_i (rk_i),
    .nxt_o(up_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      up_q <= pt_i[2*WORD_W-1:WORD_W];
      lo_q <= pt_i[WORD_W-1:0];
    end else if (round_i) begin
      up_q <= up_nxt;
      lo_q <= up_q;
    end
  end

  assign st_o = {up_q, lo_q};

endmodule

// File: rtl/feistel_round_engine.sv
module feistel_round_engine #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned RND_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [2*WORD_W-1:0] pt_i,
  input  logic [RND_W-1:0]    rounds_i,
  input  logic [WORD_W-1:0]   key_i,
  output logic                key_req_o,
  output logic [RND_W-1:0]    key_idx_o,
  output logic [2*WORD_W-1:0] ct_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int unsigned BLK_W = 2 * WORD_W;

  // named internal events
  logic             load_fire;
  logic             round_fire;
  logic             last_round;
  logic [RND_W-1:0] idx;
  logic [BLK_W-1:0] state;

  feistel_ctrl #(.RND_W(RND_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .rounds_i(rounds_i),
    .load_o  (load_fire),
    .round_o (round_fire),
    .last_o  (last_round),
    .idx_o   (idx),
    .done_o  (done_o)
  );

  feistel_state #(.WORD_W(WORD_W)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_fire),
    .round_i(round_fire),
    .pt_i   (pt_i),
    .rk_i   (key_i),
    .st_o   (state)
  );

  assign key_req_o = round_fire;
  assign key_idx_o = idx;
  assign busy_o    = round_fire;
  assign ct_o      = state;

endmodule

// File: rtl/feistel_round_engine_chk.sv
module feistel_round_engine_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned RND_W  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [2*WORD_W-1:0] pt_i,
  input logic                key_req_o,
  input logic [RND_W-1:0]    key_idx_o,
  input logic [2*WORD_W-1:0] ct_o,
  input logic                busy_o,
  input logic                done_o,
  input logic                load_fire,
  input logic                round_fire,
  input logic                last_round
);

  AST_LOAD_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> ct_o == $past(pt_i)); // R2

  AST_LOWER_TAKES_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    round_fire |=> ct_o[WORD_W-1:0] == $past(ct_o[2*WORD_W-1:WORD_W])); // R4

  AST_FIRST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (!key_req_o || key_idx_o == '0)); // R5

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (round_fire && !last_round) |=> (key_req_o && key_idx_o == $past(key_idx_o) + RND_W'(1))); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> (done_o && !busy_o)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o); // R7

  AST_CT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(ct_o)); // R7

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_round) |=> (busy_o && !done_o)); // R8

endmodule

bind feistel_round_engine feistel_round_engine_chk #(.WORD_W(WORD_W), .RND_W(RND_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .pt_i      (pt_i),
  .key_req_o (key_req_o),
  .key_idx_o (key_idx_o),
  .ct_o      (ct_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .load_fire (load_fire),
  .round_fire(round_fire),
  .last_round(last_round)
);

// File: tb/feistel_round_engine_test.sv
`timescale 1ns/1ps
module feistel_round_engine_test;
  localparam int W  = 16;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [2*W-1:0] pt_i = '0;
  logic [RW-1:0] rounds_i = '0;
  logic [W-1:0]  key_i;
  logic          key_req_o;
  logic [RW-1:0] key_idx_o;
  logic [2*W-1:0] ct_o;
  logic          busy_o;
  logic          done_o;

  logic [W-1:0] keymem [256];

  int total = 0;
  int bad   = 0;
  bit chk_en = 1'b0;

  always #2.5 clk = ~clk;

  feistel_round_engine #(.WORD_W(W), .RND_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pt_i(pt_i),
    .rounds_i(rounds_i), .key_i(key_i), .key_req_o(key_req_o),
    .key_idx_o(key_idx_o), .ct_o(ct_o), .busy_o(busy_o), .done_o(done_o)
  );

  assign key_i = keymem[key_idx_o];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] rol(input logic [W-1:0] x, input int s);
    logic [2*W-1:0] d;
    d = {x, x} << s;
    return d[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] f_round(input logic [W-1:0] u, input logic [W-1:0] l, input logic [W-1:0] k);
    return (rol(u, 1) & rol(u, 8)) ^ rol(u, 2) ^ l ^ k;
  endfunction

  function automatic logic [2*W-1:0] encrypt(input logic [2*W-1:0] pt, input int n);
    logic [W-1:0] u, l, t;
    u = pt[2*W-1:W];
    l = pt[W-1:0];
    for (int r = 0; r < n; r++) begin
      t = f_round(u, l, keymem[r]);
      l = u;
      u = t;
    end
    return {u, l};
  endfunction

  task automatic fill_keys(input int seed);
    for (int i = 0; i < 256; i++)
      keymem[i] = (seed == 0) ? '0 : W'((seed * 40503) ^ (i * 9973) ^ (i << 7));
  endtask

  // cycle-by-cycle behavioural model
  logic [W-1:0] mu, ml;
  bit m_busy, m_done;
  int m_idx, m_lim;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mu = '0; ml = '0; m_busy = 0; m_done = 0; m_idx = 0; m_lim = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          mu = pt_i[2*W-1:W];
          ml = pt_i[W-1:0];
          m_idx = 0;
          m_lim = int'(rounds_i);
          if (m_lim == 0) m_done = 1;
          else m_busy = 1;
        end
      end else begin
        logic [W-1:0] nu;
        nu = f_round(mu, ml, keymem[m_idx]);
        ml = mu;
        mu = nu;
        m_idx++;
        if (m_idx == m_lim) begin
          m_busy = 0;
          m_done = 1;
          m_idx = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      chk(ct_o === {mu, ml}, "R3/R4 state", ct_o, {mu, ml});
      chk(done_o === m_done, "R6/R7 done", done_o, m_done);
      chk(key_req_o === m_busy, "R5 key_req", key_req_o, m_busy);
      if (m_busy) chk(int'(key_idx_o) == m_idx, "R5 key_idx", key_idx_o, m_idx);
    end
  end

  // one operation: start, wait for done, check latency and result
  task automatic run_op(input logic [2*W-1:0] pt, input int n, input int seed, input string tag);
    int lat;
    int reqs;
    fill_keys(seed);
    @(negedge clk);
    start_i = 1'b1; pt_i = pt; rounds_i = RW'(n);
    @(negedge clk);
    start_i = 1'b0;
    lat = 1; reqs = 0;
    while (!done_o && lat < 600) begin
      if (key_req_o) reqs++;
      @(negedge clk);
      lat++;
    end
    chk(lat == n + 1, {tag, " R6 latency"}, lat, n + 1);
    chk(reqs == n, {tag, " R5 request count"}, reqs, n);
    chk(ct_o === encrypt(pt, n), {tag, " R3 ciphertext"}, ct_o, encrypt(pt, n));
  endtask

  initial begin
    logic [2*W-1:0] held;
    int lat;
    fill_keys(1);
    repeat (3) @(negedge clk);
    // R1: during reset
    chk(ct_o === '0 && !done_o && !key_req_o && !busy_o, "R1 reset", ct_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ct_o === '0 && !done_o && !key_req_o && !busy_o, "R1 after release", ct_o, 0);
    chk_en = 1'b1;

    run_op(32'h6565_6877, 32, 1, "base32");
    run_op(32'hA5A5_0F0F, 36, 7, "r36");
    // R4: one round, lower word must be the old upper word
    run_op(32'h1234_5678, 1, 3, "single");
    chk(ct_o[W-1:0] === 16'h1234, "R4 lower=old upper", ct_o[W-1:0], 16'h1234);
    // R9 and R2: zero rounds
    run_op(32'hDEAD_BEEF, 0, 5, "zero");
    chk(ct_o === 32'hDEAD_BEEF, "R9 R2 zero-round passthrough", ct_o, 32'hDEAD_BEEF);
    // R10: no whitening
    run_op(32'h0000_0000, 32, 0, "nowhite");
    chk(ct_o === '0, "R10 zero in zero out", ct_o, 0);
    run_op(32'hFFFF_FFFF, 255, 11, "max");

    // R7: output holds while idle
    held = ct_o;
    repeat (10) @(negedge clk);
    chk(ct_o === held, "R7 ct hold", ct_o, held);
    chk(!done_o, "R7 done low while idle", done_o, 0);

    // R8: start during rounds is ignored
    fill_keys(9);
    @(negedge clk);
    start_i = 1'b1; pt_i = 32'h0BAD_F00D; rounds_i = RW'(20);
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    start_i = 1'b1; pt_i = 32'h1111_2222; rounds_i = RW'(3);
    @(negedge clk);
    start_i = 1'b0;
    lat = 6;
    while (!done_o && lat < 600) begin @(negedge clk); lat++; end
    chk(lat == 21, "R8 latency unchanged", lat, 21);
    chk(ct_o === encrypt(32'h0BAD_F00D, 20), "R8 result unchanged", ct_o, encrypt(32'h0BAD_F00D, 20));

    // R11: start in the done cycle
    start_i = 1'b1; pt_i = 32'h3C3C_C3C3; rounds_i = RW'(5);
    @(negedge clk);
    start_i = 1'b0;
    chk(key_req_o === 1'b1, "R11 back-to-back accepted", key_req_o, 1);
    lat = 1;
    while (!done_o && lat < 600) begin @(negedge clk); lat++; end
    chk(lat == 6, "R11 latency", lat, 6);
    chk(ct_o === encrypt(32'h3C3C_C3C3, 5), "R11 result", ct_o, encrypt(32'h3C3C_C3C3, 5));

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule